// File: doc/BRIEF.md
# SDRAM command mode issuer

This block turns command words written by software into SDRAM command sequences on a simple per-device command bus. Each word selects a command mode, one or both of two attached devices, a repeat count for auto-refresh, and a value to load into the devices' mode register. While a sequence runs, including the timing gap after its last command, a busy flag stays high. Software polls this flag between the steps of its power-up routine: clock enable, precharge-all, a burst of auto-refreshes, load mode, then normal.

The block also holds the delay fields used between commands and a refresh-rate counter. In normal operation the counter raises periodic auto-refresh requests to every device that has had its mode register loaded. A request that falls due while a software command is running is held back and issued as soon as the engine is free. A command word written while busy is high is dropped, and a sticky error flag records it.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: Command word bits 2:0 pick the mode: 0 normal, 1 clock enable, 2 precharge-all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down. Code 7 drives no command and leaves CKE unchanged.
- R2: Bit 4 of the command word targets device 1 (`sd_cs_n[0]`) and bit 3 targets device 2 (`sd_cs_n[1]`). With both bits set, both chip selects go low in the same cycle.
- R3: Bits 8:5 give the auto-refresh repeat count N. N refresh commands go out, each one tRC+1 cycles after the previous. A count of 0 behaves as 1.
- R4: Bus encodings as {RAS_n, CAS_n, WE_n} are: precharge 010, refresh 001, load mode 000, idle 111. During load mode, command word bits 21:9 appear on the address bus.
- R5: Busy rises on the edge that accepts a command. The first command appears one cycle later. Busy falls W+1 cycles after the last command, where W is that mode's delay field (0 for modes without a delay). Chip selects go low only while busy is high.
- R6: The timing word holds 4-bit fields at these bit positions: tMRD at 3:0, tXSR at 7:4, tRC at 15:12, tRP at 23:20. Each delay lasts the field value plus one cycle: tRP after precharge, tRC after refresh, tMRD after load mode, and tXSR after waking with normal mode.
- R7: The refresh word holds the reload count C in bits 13:1. When C is nonzero, CKE is high and at least one device has had its mode loaded, an auto-refresh goes to all such devices every C+1 cycles.
- R8: A refresh that falls due during a software command is held. It is issued two cycles after busy falls.
- R9: A command word written while busy is high drives nothing and sets a sticky error flag.
- R10: Self-refresh issues a refresh command and lowers CKE on the next cycle. A later normal-mode command raises CKE and holds busy through tXSR.
- R11: After reset, CKE is low, both chip selects are high, and busy and error are low. Clock enable raises CKE and power-down lowers it. CKE changes only while busy is high.
- R12: Precharge-all drives address bit 10 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Mode, targets, repeat count, mode-register value |
| tim_wr | input | 1 | Timing word write strobe |
| tim_word | input | 32 | Packed delay fields |
| rfr_wr | input | 1 | Refresh word write strobe |
| rfr_word | input | 32 | Refresh reload count in bits 13:1 |
| busy | output | 1 | Command sequence in progress |
| err | output | 1 | Sticky flag: write while busy |
| sd_cke | output | 1 | Clock enable to the devices |
| sd_cs_n | output | 2 | Chip selects, bit 0 device 1, bit 1 device 2 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | 13 | Address bus |

## Verification
A wrong wait count shows up as a busy flag that falls one or more cycles early or late, and as auto-refresh commands spaced wrongly within a burst. Both are visible within a few cycles of the affected command. A wrong repeat register shows up as missing or extra refresh commands. A wrong CKE state shows up as a CKE level one cycle off around self-refresh and power-down. The periodic-refresh path is judged by the exact spacing between refreshes to both devices, and by the exact cycle at which a held refresh appears after a long software command. A dropped or misrouted target bit appears at once on the chip selects.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int CSR_W = 32;
  localparam int TF_W  = 4;
  localparam int TF_MRD = 0;
  localparam int TF_XSR = 4;
  localparam int TF_RC  = 12;
  localparam int TF_RP  = 20;
  localparam int A10    = 10;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_CLK_EN   = 3'd1,
    MODE_PRE_ALL  = 3'd2,
    MODE_AUTO_REF = 3'd3,
    MODE_LOAD_MR  = 3'd4,
    MODE_SELF_REF = 3'd5,
    MODE_PWR_DOWN = 3'd6,
    MODE_RSVD     = 3'd7
  } cmd_mode_e;

  typedef enum logic [1:0] {BUS_NOP, BUS_PRE, BUS_REF, BUS_LMR} bus_op_e;

  typedef struct packed {
    logic [TF_W-1:0] mrd;
    logic [TF_W-1:0] xsr;
    logic [TF_W-1:0] rc;
    logic [TF_W-1:0] rp;
  } sd_timing_t;

  // Pick the used delay fields out of a timing word.
  function automatic sd_timing_t unpack_timing(input logic [CSR_W-1:0] w);
    sd_timing_t t;
    t.mrd = w[TF_MRD +: TF_W];
    t.xsr = w[TF_XSR +: TF_W];
    t.rc  = w[TF_RC  +: TF_W];
    t.rp  = w[TF_RP  +: TF_W];
    return t;
  endfunction

  // {ras_n, cas_n, we_n} for a bus operation.
  function automatic logic [2:0] op_pins(input bus_op_e op);
    case (op)
      BUS_PRE: return 3'b010;
      BUS_REF: return 3'b001;
      BUS_LMR: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  // Effective repeat count: only auto-refresh repeats, zero counts as one.
  function automatic int unsigned eff_repeat(input cmd_mode_e m, input int unsigned n);
    return (m == MODE_AUTO_REF && n != 0) ? n : 1;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int RPT_W = 4,
  parameter int MRV_W = 13
) (
  input  logic [CSR_W-1:0] cmd_word,
  output cmd_mode_e        mode,
  output logic [1:0]       tgt,
  output logic [RPT_W-1:0] rpt,
  output logic [MRV_W-1:0] mrv
);
  localparam int TGT_DEV1 = 4;
  localparam int TGT_DEV2 = 3;
  localparam int RPT_LSB  = 5;
  localparam int MRV_LSB  = RPT_LSB + RPT_W;
  localparam int TOP_USED = MRV_LSB + MRV_W;

  logic unused_cmd_bits;

  assign mode   = cmd_mode_e'(cmd_word[2:0]);
  assign tgt[0] = cmd_word[TGT_DEV1];
  assign tgt[1] = cmd_word[TGT_DEV2];
  assign rpt    = cmd_word[RPT_LSB +: RPT_W];
  assign mrv    = cmd_word[MRV_LSB +: MRV_W];
  assign unused_cmd_bits = ^cmd_word[CSR_W-1:TOP_USED];
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count_i,
  input  logic             enable,
  input  logic             ack,
  output logic             due,
  output logic             tick
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             due_q;

  assign tick = !load && enable && (reload_q != '0) && (cnt_q == '0);
  assign due  = due_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      due_q    <= 1'b0;
    end else begin
      if (ack) due_q <= 1'b0;
      if (load) begin
        reload_q <= count_i;
        cnt_q    <= count_i;
        if (count_i == '0) due_q <= 1'b0;
      end else if (enable && reload_q != '0) begin
        if (cnt_q == '0) begin
          due_q <= 1'b1;
          cnt_q <= reload_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RPT_W  = 4,
  parameter int MRV_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_user,
  input  cmd_mode_e         u_mode,
  input  logic [1:0]        u_tgt,
  input  logic [RPT_W-1:0]  u_rpt,
  input  logic [MRV_W-1:0]  u_mrv,
  input  logic              start_rfr,
  input  logic [1:0]        rfr_tgt,
  input  sd_timing_t        tim,
  output logic              busy,
  output logic              cke,
  output logic [1:0]        init_mask,
  output logic [1:0]        cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              issue_evt,
  output logic              done_evt
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

  st_e              state;
  cmd_mode_e        mode_q;
  logic [1:0]       tgt_q, cs_q, init_q;
  logic [RPT_W-1:0] rpt_left;
  logic [MRV_W-1:0] mrv_q;
  logic [TF_W-1:0]  wcnt;
  logic             cke_q;
  bus_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;

  bus_op_e           iss_op;
  logic [TF_W-1:0]   iss_wait;
  logic              iss_cke;
  logic [ADDR_W-1:0] iss_addr;

  // What one issue step of the latched mode does.
  always_comb begin
    iss_op   = BUS_NOP;
    iss_wait = '0;
    iss_cke  = cke_q;
    iss_addr = '0;
    case (mode_q)
      MODE_PRE_ALL: begin
        iss_op = BUS_PRE;
        iss_wait = tim.rp;
        iss_addr[A10] = 1'b1;
      end
      MODE_AUTO_REF: begin
        iss_op = BUS_REF;
        iss_wait = tim.rc;
      end
      MODE_LOAD_MR: begin
        iss_op = BUS_LMR;
        iss_wait = tim.mrd;
        iss_addr = ADDR_W'(mrv_q);
      end
      MODE_SELF_REF: iss_op = BUS_REF;
      MODE_CLK_EN:   iss_cke = 1'b1;
      MODE_PWR_DOWN: iss_cke = 1'b0;
      MODE_NORMAL: begin
        if (!cke_q) begin
          iss_cke  = 1'b1;
          iss_wait = tim.xsr;
        end
      end
      default: ;
    endcase
  end

  assign issue_evt = (state == S_ISSUE) ||
                     (state == S_WAIT && wcnt == '0 && rpt_left != '0);
  assign done_evt  = (state == S_WAIT && wcnt == '0 && rpt_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= MODE_NORMAL;
      tgt_q    <= '0;
      rpt_left <= '0;
      mrv_q    <= '0;
      wcnt     <= '0;
      cke_q    <= 1'b0;
      init_q   <= '0;
      op_q     <= BUS_NOP;
      cs_q     <= '1;
      addr_q   <= '0;
    end else begin
      op_q   <= BUS_NOP;
      cs_q   <= '1;
      addr_q <= '0;
      case (state)
        S_IDLE: begin
          if (start_user) begin
            mode_q   <= u_mode;
            tgt_q    <= u_tgt;
            rpt_left <= RPT_W'(eff_repeat(u_mode, int'(u_rpt)));
            mrv_q    <= u_mrv;
            state    <= S_ISSUE;
          end else if (start_rfr) begin
            mode_q   <= MODE_AUTO_REF;
            tgt_q    <= rfr_tgt;
            rpt_left <= RPT_W'(1);
            state    <= S_ISSUE;
          end
        end
        S_WAIT: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - TF_W'(1);
          end else if (rpt_left == '0) begin
            if (mode_q == MODE_SELF_REF) cke_q <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: ;
      endcase
      if (issue_evt) begin
        op_q     <= iss_op;
        cs_q     <= (iss_op == BUS_NOP) ? 2'b11 : ~tgt_q;
        addr_q   <= iss_addr;
        cke_q    <= iss_cke;
        wcnt     <= iss_wait;
        rpt_left <= rpt_left - RPT_W'(1);
        state    <= S_WAIT;
        if (mode_q == MODE_LOAD_MR) init_q <= init_q | tgt_q;
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_cs
    assign cs_n[d] = cs_q[d];
  end

  assign {ras_n, cas_n, we_n} = op_pins(op_q);
  assign addr      = addr_q;
  assign busy      = (state != S_IDLE);
  assign cke       = cke_q;
  assign init_mask = init_q;
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RFR_W  = 13,
  parameter int RPT_W  = 4,
  parameter int MRV_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              tim_wr,
  input  logic [31:0]       tim_word,
  input  logic              rfr_wr,
  input  logic [31:0]       rfr_word,
  output logic              busy,
  output logic              err,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr
);
  cmd_mode_e        u_mode;
  logic [1:0]       u_tgt, init_mask;
  logic [RPT_W-1:0] u_rpt;
  logic [MRV_W-1:0] u_mrv;
  sd_timing_t       tim_q;
  logic             err_q;
  logic             accept, collide, start_rfr, rfr_due, rfr_tick, rfr_en;
  logic             issue_evt, done_evt;
  logic             unused_cfg_bits;

  assign accept    = cmd_wr && !busy;
  assign collide   = cmd_wr && busy;
  assign start_rfr = rfr_due && !busy && !cmd_wr;
  assign rfr_en    = sd_cke && (init_mask != '0);
  assign unused_cfg_bits = ^{rfr_word[0], rfr_word[CSR_W-1:RFR_W+1],
                             tim_word[11:8], tim_word[19:16],
                             tim_word[CSR_W-1:24], rfr_tick};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (tim_wr)  tim_q <= unpack_timing(tim_word);
      if (collide) err_q <= 1'b1;
    end
  end
  assign err = err_q;

  sdram_cmd_decode #(.RPT_W(RPT_W), .MRV_W(MRV_W)) u_decode (
    .cmd_word (cmd_word),
    .mode     (u_mode),
    .tgt      (u_tgt),
    .rpt      (u_rpt),
    .mrv      (u_mrv)
  );

  sdram_refresh_timer #(.CNT_W(RFR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rfr_wr),
    .count_i (rfr_word[RFR_W:1]),
    .enable  (rfr_en),
    .ack     (start_rfr),
    .due     (rfr_due),
    .tick    (rfr_tick)
  );

  sdram_cmd_engine #(.ADDR_W(ADDR_W), .RPT_W(RPT_W), .MRV_W(MRV_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_user (accept),
    .u_mode     (u_mode),
    .u_tgt      (u_tgt),
    .u_rpt      (u_rpt),
    .u_mrv      (u_mrv),
    .start_rfr  (start_rfr),
    .rfr_tgt    (init_mask),
    .tim        (tim_q),
    .busy       (busy),
    .cke        (sd_cke),
    .init_mask  (init_mask),
    .cs_n       (sd_cs_n),
    .ras_n      (sd_ras_n),
    .cas_n      (sd_cas_n),
    .we_n       (sd_we_n),
    .addr       (sd_addr),
    .issue_evt  (issue_evt),
    .done_evt   (done_evt)
  );
endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       busy,
  input logic       err,
  input logic       sd_cke,
  input logic [1:0] sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic       a10,
  input logic       issue_evt,
  input logic       done_evt
);
  assert_cs_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != 2'b11) |-> busy);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> busy);

  assert_issue_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |-> busy);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

  assert_collide_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_cke_moves_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cke != $past(sd_cke)) |-> $past(busy));

  assert_pre_a10_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != 2'b11 && !sd_ras_n && sd_cas_n && !sd_we_n) |-> a10);
endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .busy      (busy),
  .err       (err),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .a10       (sd_addr[10]),
  .issue_evt (issue_evt),
  .done_evt  (done_evt)
);

// File: tb/sdram_cmd_issuer_bench.sv
module sdram_cmd_issuer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, tim_wr = 1'b0, rfr_wr = 1'b0;
  logic [31:0] cmd_word = '0, tim_word = '0, rfr_word = '0;
  logic        busy, err, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_cs_n;
  logic [12:0] sd_addr;

  int cyc = 0, checks = 0, errors = 0;
  int nref = 0, last_ref = -1, rfr_period = 0, bdone = 0;
  bit per_on = 0, chk_spacing = 0, finished = 0;

  typedef struct {
    int          cyc;
    logic [1:0]  cs;
    logic [2:0]  rcw;
    logic [12:0] addr;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;
  logic [2:0] mon_rcw;

  sdram_cmd_issuer u_sdram_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .tim_wr(tim_wr), .tim_word(tim_word), .rfr_wr(rfr_wr), .rfr_word(rfr_word),
    .busy(busy), .err(err), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: every chip-select-active cycle is either a periodic refresh or
  // the next item the driver queued.
  always @(negedge clk) begin
    if (rst_n && sd_cs_n != 2'b11) begin
      mon_rcw = {sd_ras_n, sd_cas_n, sd_we_n};
      if (per_on && mon_rcw == 3'b001 && sd_cs_n == 2'b00) begin
        if (chk_spacing && last_ref >= 0)
          chk(cyc - last_ref == rfr_period, "R7", "refresh spacing",
              cyc - last_ref, rfr_period);
        last_ref = cyc;
        nref++;
      end else if (exp_q.size() == 0) begin
        chk(0, "R9", "unexpected command cs_n", int'(sd_cs_n), 3);
      end else begin
        e = exp_q.pop_front();
        chk(cyc == e.cyc, e.req, "command cycle", cyc, e.cyc);
        chk(sd_cs_n == e.cs, e.req, "chip selects", int'(sd_cs_n), int'(e.cs));
        chk(mon_rcw == e.rcw, e.req, "ras/cas/we", int'(mon_rcw), int'(e.rcw));
        chk(sd_addr == e.addr, e.req, "address", int'(sd_addr), int'(e.addr));
      end
    end
  end

  // Driver: pushes the expected commands, writes the word, checks busy timing.
  task automatic do_cmd(input logic [31:0] w, input int n, input int wt,
                        input logic [1:0] cs, input logic [2:0] rcw,
                        input logic [12:0] addr, input string req,
                        input bit collide);
    int c0, endc;
    @(negedge clk);
    while (busy) @(negedge clk);
    c0 = cyc + 1;
    if (rcw != 3'b111)
      for (int k = 0; k < n; k++)
        exp_q.push_back('{c0 + 1 + k * (wt + 1), cs, rcw, addr, req});
    cmd_word = w;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy === 1'b1, "R5", "busy after accept", int'(busy), 1);
    if (collide) begin
      cmd_word = 32'h1A;
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(err === 1'b1, "R9", "error after write while busy", int'(err), 1);
    end
    while (busy) @(negedge clk);
    endc = c0 + 1 + n * (wt + 1);
    chk(cyc == endc, req, "busy fall cycle", cyc, endc);
    chk(exp_q.size() == 0, req, "commands left over", exp_q.size(), 0);
    bdone = cyc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sd_cke == 1'b0, "R11", "reset cke", int'(sd_cke), 0);
    chk(sd_cs_n == 2'b11, "R11", "reset cs_n", int'(sd_cs_n), 3);
    chk(busy == 1'b0 && err == 1'b0, "R11", "reset busy/err",
        int'({busy, err}), 0);
    rst_n = 1'b1;
    // R6: tMRD=1, tXSR=3, tRC=2, tWR=5 (unused), tRP=1
    tim_word = 32'h0015_2031;
    tim_wr = 1'b1;
    @(negedge clk);
    tim_wr = 1'b0;

    do_cmd(32'h11, 1, 0, 2'b11, 3'b111, 13'h0, "R11", 0);
    chk(sd_cke == 1'b1, "R11", "cke after clock enable", int'(sd_cke), 1);
    do_cmd(32'h1A, 1, 1, 2'b00, 3'b010, 13'h400, "R12", 0);       // R2 both, R6 tRP
    do_cmd(32'h73, 3, 2, 2'b10, 3'b001, 13'h0, "R3", 0);          // R2 device 1
    do_cmd(32'h0B, 1, 2, 2'b01, 3'b001, 13'h0, "R3", 0);          // R2 device 2, count 0
    do_cmd(32'h641C, 1, 1, 2'b00, 3'b000, 13'h32, "R4", 1);       // R9 collision
    chk(err == 1'b1, "R9", "error sticky", int'(err), 1);
    do_cmd(32'h18, 1, 0, 2'b11, 3'b111, 13'h0, "R1", 0);

    // R7: periodic refresh every C+1 cycles
    rfr_period = 21;
    per_on = 1;
    chk_spacing = 1;
    @(negedge clk);
    rfr_word = 32'd20 << 1;
    rfr_wr = 1'b1;
    @(negedge clk);
    rfr_wr = 1'b0;
    repeat (120) @(negedge clk);
    chk(nref >= 4, "R7", "periodic refresh count", nref, 4);

    // R8: refresh held during a long command, issued two cycles after
    chk_spacing = 0;
    do_cmd(32'h1F3, 15, 2, 2'b10, 3'b001, 13'h0, "R8", 0);
    repeat (6) @(negedge clk);
    chk(last_ref == bdone + 2, "R8", "held refresh cycle", last_ref, bdone + 2);

    rfr_word = '0;
    rfr_wr = 1'b1;
    @(negedge clk);
    rfr_wr = 1'b0;
    repeat (10) @(negedge clk);
    per_on = 0;

    do_cmd(32'h1D, 1, 0, 2'b00, 3'b001, 13'h0, "R10", 0);
    chk(sd_cke == 1'b0, "R10", "cke after self-refresh", int'(sd_cke), 0);
    do_cmd(32'h18, 1, 3, 2'b11, 3'b111, 13'h0, "R10", 0);         // tXSR wait
    chk(sd_cke == 1'b1, "R10", "cke after wake", int'(sd_cke), 1);
    do_cmd(32'h1E, 1, 0, 2'b11, 3'b111, 13'h0, "R11", 0);
    chk(sd_cke == 1'b0, "R11", "cke after power-down", int'(sd_cke), 0);
    do_cmd(32'h19, 1, 0, 2'b11, 3'b111, 13'h0, "R11", 0);
    chk(sd_cke == 1'b1, "R11", "cke after clock enable", int'(sd_cke), 1);
    do_cmd(32'h1F, 1, 0, 2'b11, 3'b111, 13'h0, "R1", 0);
    chk(sd_cke == 1'b1, "R1", "code 7 leaves cke", int'(sd_cke), 1);
    chk(err == 1'b1, "R9", "error still set", int'(err), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (!finished && cyc > 20000) begin
      chk(0, "R5", "watchdog expired", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule